// File: doc/BRIEF.md
# Paired Interrupt Controller with Programmable Vector

This block collects interrupt sources from four groups of two serial channels and presents them as two active-high interrupt lines. Each group keeps an 8-bit pending-status register and an 8-bit enable mask. Channel logic outside the block raises and drops status bits with one-cycle set and clear pulses. A line is high while any enabled pending bit exists in either of the two groups wired to it: groups 0 and 1 share line 0, and groups 2 and 3 share line 1.

A byte-wide register bus reaches four spaces, chosen by a 2-bit space code. The I/O space holds the per-group status (read) and mask (write) registers. The ID space and the memory space each accept a write of the 8-bit vector. The acknowledge space returns that vector when a handler reads the slot of either line. A small access state machine has two states. BUS_IDLE moves to BUS_RESP on a read strobe. BUS_RESP stays in BUS_RESP on another read strobe and otherwise returns to BUS_IDLE. Read data is valid while the machine is in BUS_RESP.

Top module: `ic_pair_top`

## Requirements
- R1: After reset every status register, every mask register and the vector are zero, both interrupt lines are low and no read response is valid.
- R2: A set pulse on bit 8*g+b of `evt_set` makes status bit b of group g equal to 1 after the next clock edge. Within each group, bits 0 to 2 belong to the even channel, bits 4 to 6 belong to the odd channel, and bits 3 and 7 are shared.
- R3: A clear pulse on bit 8*g+b of `evt_clr` makes that status bit 0 after the next edge. If a set pulse and a clear pulse hit the same bit in the same cycle, the set wins.
- R4: Bus reads, acknowledge reads and bus writes never change any status bit.
- R5: A read in the I/O space (space code 0) at byte address 32*g+0x0A returns the status of group g. The data and `bus_rvalid` appear in the cycle after the read strobe.
- R6: A write in the I/O space at byte address 32*g+0x0A loads the mask of group g. `irq[0]` is high exactly when (status AND mask) is nonzero in group 0 or group 1. `irq[1]` follows the same rule for groups 2 and 3.
- R7: A line re-evaluates after every change of status or mask. It falls once its last enabled pending bit is cleared or masked off.
- R8: A write to byte address 1 in the ID space (code 1) or in the memory space (code 3) loads the vector. Writes to other addresses in those spaces are ignored, and reads in those spaces return 0.
- R9: A read in the acknowledge space (code 2) at address 0 or address 2 returns the vector. A read there at any other address returns 0. Writes to that space are ignored.
- R10: I/O-space accesses at any other address, including any address with bit 7 set, read 0 and leave every mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_space | input | 2 | Space code: 0 I/O, 1 ID, 2 acknowledge, 3 memory |
| bus_addr | input | 8 | Byte address within the space |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid, the cycle after bus_rd |
| evt_set | input | 32 | Status set pulses, 8 per group |
| evt_clr | input | 32 | Status clear pulses, 8 per group |
| irq | output | 2 | Active-high interrupt lines |

## Verification
Two collisions can occur in a single cycle. The first is a set pulse and a clear pulse on the same status bit. The bench drives both together and then reads the status back, expecting the bit to be 1. The second is a set pulse arriving in the same cycle as a mask write that enables it. The bench issues both from one falling edge and expects the line to rise one edge later, with nothing lost. Read results pass through a scoreboard queue that is filled when the read is issued and emptied as `bus_rvalid` appears.

// File: rtl/ic_pair_pkg.sv
package ic_pair_pkg;
    typedef enum logic [1:0] {
        SP_IO  = 2'd0,
        SP_ID  = 2'd1,
        SP_ACK = 2'd2,
        SP_MEM = 2'd3
    } space_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_st_e;

    // Status/mask byte offset inside a group window (raw byte address)
    localparam logic [4:0] STAT_OFS = 5'h0A;
    localparam int unsigned GRP_SHIFT = 5;
endpackage

// File: rtl/ic_group.sv
module ic_group #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_i,
    input  logic [DW-1:0] clr_i,
    input  logic          mask_we,
    input  logic [DW-1:0] mask_d,
    output logic [DW-1:0] status_o,
    output logic [DW-1:0] mask_o,
    output logic          pend_o
);
    logic [DW-1:0] status_q, mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= (status_q & ~clr_i) | set_i;
            if (mask_we) mask_q <= mask_d;
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign pend_o   = |(status_q & mask_q);

    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));
    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((status_o & $past(clr_i & ~set_i)) == '0));
    a_r4_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(status_o));
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_o == $past(mask_d)));
endmodule

// File: rtl/ic_bus_ctl.sv
module ic_bus_ctl
    import ic_pair_pkg::*;
#(
    parameter int unsigned NGROUPS = 4,
    parameter int unsigned DW      = 8,
    parameter int unsigned AW      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            space,
    input  logic [AW-1:0]         addr,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [DW-1:0]         wdata,
    input  logic [NGROUPS*DW-1:0] status_all,
    output logic [NGROUPS-1:0]    mask_we,
    output logic [DW-1:0]         mask_d,
    output logic [DW-1:0]         rdata,
    output logic                  rvalid
);
    localparam int unsigned GIW = (NGROUPS > 1) ? $clog2(NGROUPS) : 1;

    bus_st_e       st_q, st_n;
    logic [DW-1:0] vec_q, rdata_q, rd_val;
    logic [GIW-1:0] grp;
    logic          io_hit, vec_we;

    assign grp    = GIW'(addr >> GRP_SHIFT);
    assign io_hit = ((addr >> (GRP_SHIFT + GIW)) == '0) && (addr[4:0] == STAT_OFS);
    assign vec_we = wr && (space == SP_ID || space == SP_MEM) && (addr == AW'(1));
    assign mask_d = wdata;

    for (genvar g = 0; g < NGROUPS; g++) begin : g_we
        assign mask_we[g] = wr && (space == SP_IO) && io_hit && (grp == GIW'(g));
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            BUS_IDLE: if (rd) st_n = BUS_RESP;
            BUS_RESP: if (!rd) st_n = BUS_IDLE;
        endcase
    end

    always_comb begin
        rd_val = '0;
        unique case (space)
            SP_IO:  if (io_hit) rd_val = status_all[grp*DW +: DW];
            SP_ACK: if (addr == AW'(0) || addr == AW'(2)) rd_val = vec_q;
            SP_ID:  rd_val = '0;
            SP_MEM: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BUS_IDLE;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            vec_q   <= '0;
        end else begin
            if (rd)     rdata_q <= rd_val;
            if (vec_we) vec_q   <= wdata;
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = (st_q == BUS_RESP);

    a_r5_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    a_r8_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(vec_q));
    a_r9_ack_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && space == SP_ACK && addr != AW'(0) && addr != AW'(2)) |=> (rdata == '0));
    a_r10_we_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_we));
endmodule

// File: rtl/ic_pair_top.sv
module ic_pair_top #(
    parameter int unsigned NGROUPS = 4,
    parameter int unsigned DW      = 8,
    parameter int unsigned AW      = 8,
    localparam int unsigned NLINES = NGROUPS / 2,
    localparam int unsigned EW     = NGROUPS * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_space,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_rvalid,
    input  logic [EW-1:0]     evt_set,
    input  logic [EW-1:0]     evt_clr,
    output logic [NLINES-1:0] irq
);
    logic [EW-1:0]      status_all, mask_all;
    logic [NGROUPS-1:0] mask_we, pend;
    logic [DW-1:0]      mask_d;

    ic_bus_ctl #(.NGROUPS(NGROUPS), .DW(DW), .AW(AW)) u_bus (
        .clk(clk), .rst_n(rst_n), .space(bus_space), .addr(bus_addr),
        .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata), .status_all(status_all),
        .mask_we(mask_we), .mask_d(mask_d), .rdata(bus_rdata), .rvalid(bus_rvalid)
    );

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        ic_group #(.DW(DW)) u_grp (
            .clk(clk), .rst_n(rst_n),
            .set_i(evt_set[g*DW +: DW]), .clr_i(evt_clr[g*DW +: DW]),
            .mask_we(mask_we[g]), .mask_d(mask_d),
            .status_o(status_all[g*DW +: DW]), .mask_o(mask_all[g*DW +: DW]),
            .pend_o(pend[g])
        );
    end

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        assign irq[l] = pend[2*l] | pend[2*l+1];

        // R6: a line with both of its masks cleared stays low
        a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_all[2*l*DW +: 2*DW] == '0) |-> !irq[l]);
        // R7: a line with no pending status in its groups stays low
        a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (status_all[2*l*DW +: 2*DW] == '0) |-> !irq[l]);
    end
endmodule

// File: tb/ic_pair_top_tb.sv
module ic_pair_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_space = 2'd0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [31:0] evt_set = '0;
    logic [31:0] evt_clr = '0;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    ic_pair_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_space(bus_space), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .evt_set(evt_set), .evt_clr(evt_clr), .irq(irq)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when a read response is valid
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (q.size() == 0) check(8'hEE, 8'h00, "R5 unexpected response");
            else begin
                exp_t e;
                e = q.pop_front();
                check(bus_rdata, e.val, e.tag);
            end
        end
    end

    task automatic bus_read(input logic [1:0] sp, input logic [7:0] a,
                            input logic [7:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        bus_space = sp; bus_addr = a; bus_rd = 1'b1;
        e.val = exp; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] sp, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_space = sp; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] s, input logic [31:0] c);
        @(negedge clk);
        evt_set = s; evt_clr = c;
        @(negedge clk);
        evt_set = '0; evt_clr = '0;
    endtask

    task automatic chk_irq(input logic [1:0] exp, input string tag);
        #1;
        check({6'd0, irq}, {6'd0, exp}, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_irq(2'b00, "R1 lines low");
        check({7'd0, bus_rvalid}, 8'h00, "R1 no response");
        for (int g = 0; g < 4; g++) bus_read(2'd0, 8'(32*g + 10), 8'h00, "R1 status zero");
        bus_read(2'd2, 8'h00, 8'h00, "R1 vector zero");

        pulse(32'h0000_0002, '0);
        bus_read(2'd0, 8'h0A, 8'h02, "R2 group0 rx bit");
        chk_irq(2'b00, "R6 unmasked stays low");
        bus_write(2'd0, 8'h0A, 8'h02);
        chk_irq(2'b01, "R6 line0 from group0");

        pulse(32'h4000_0000, '0);
        bus_read(2'd0, 8'h6A, 8'h40, "R2 group3 break odd");
        bus_write(2'd0, 8'h6A, 8'hC0);
        chk_irq(2'b11, "R6 line1 from group3");

        pulse('0, 32'h0000_0002);
        chk_irq(2'b10, "R7 line0 falls on clear");
        bus_read(2'd0, 8'h0A, 8'h00, "R3 cleared");

        pulse(32'h0000_0800, 32'h0000_0800);
        bus_read(2'd0, 8'h2A, 8'h08, "R3 set beats clear");
        bus_write(2'd0, 8'h2A, 8'h08);
        chk_irq(2'b11, "R6 line0 from group1");
        bus_write(2'd0, 8'h2A, 8'h00);
        chk_irq(2'b10, "R7 line0 falls on mask");

        bus_write(2'd1, 8'h01, 8'hA5);
        bus_read(2'd2, 8'h00, 8'hA5, "R9 ack line0");
        bus_read(2'd2, 8'h02, 8'hA5, "R9 ack line1");
        bus_read(2'd2, 8'h04, 8'h00, "R9 ack other addr");
        bus_write(2'd1, 8'h03, 8'h11);
        bus_read(2'd2, 8'h00, 8'hA5, "R8 id other addr ignored");
        bus_write(2'd3, 8'h01, 8'h3C);
        bus_read(2'd2, 8'h02, 8'h3C, "R8 mem space vector");
        bus_write(2'd3, 8'h00, 8'h77);
        bus_read(2'd2, 8'h00, 8'h3C, "R8 mem other addr ignored");
        bus_write(2'd2, 8'h00, 8'hFF);
        bus_read(2'd2, 8'h00, 8'h3C, "R9 ack write ignored");
        bus_read(2'd1, 8'h01, 8'h00, "R8 id read zero");
        bus_read(2'd3, 8'h01, 8'h00, "R8 mem read zero");

        bus_read(2'd0, 8'h6A, 8'h40, "R4 status kept after acks");
        bus_read(2'd0, 8'h2A, 8'h08, "R4 group1 kept");
        chk_irq(2'b10, "R4 lines kept");

        bus_write(2'd0, 8'hAA, 8'hFF);
        chk_irq(2'b10, "R10 bit7 write ignored");
        bus_write(2'd0, 8'h2B, 8'hFF);
        chk_irq(2'b10, "R10 wrong offset ignored");
        bus_read(2'd0, 8'h2B, 8'h00, "R10 wrong offset reads zero");
        bus_read(2'd0, 8'hAA, 8'h00, "R10 bit7 reads zero");

        pulse('0, 32'h4000_0000);
        chk_irq(2'b00, "R7 line1 falls on clear");

        // set pulse and enabling mask write in the same cycle
        @(negedge clk);
        evt_set = 32'h0001_0000;
        bus_space = 2'd0; bus_addr = 8'h4A; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        evt_set = '0; bus_wr = 1'b0;
        chk_irq(2'b10, "R6 set with mask write");
        bus_read(2'd0, 8'h4A, 8'h01, "R2 group2 tx bit");

        repeat (3) @(negedge clk);
        check(8'(q.size()), 8'h00, "R5 all responses seen");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R5 watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule